// File: doc/BRIEF.md
# Interlaced Raster Position and Sync Status Tracker

This block follows the beam of a raster display controller that can run interlaced. On every cycle that the dot-clock enable is high it advances a dot position inside the current line. At the end of a line it advances the line position, and at the end of a frame it returns to line zero. The line and dot totals come from one packed timing register. An odd/even field flag flips at each frame wrap while interlace is on. A frame counter, with a one-cycle pulse, marks the point each frame where the beam enters the first visible line.

Software reads the raster state through a status word. The word carries the current line, the field flag, and three timing flags: display active, horizontal sync released and vertical sync released. The flags come from the sync-time and front-porch registers and from a fixed back-porch parameter. A line whose parity matches the field flag uses one set of rules. A line of the other parity uses a different set. Four registers are written through a simple select/data write port.

Top module: `raster_timing`

## Requirements
- R1: The timing register (select 0) holds lines-per-frame minus one in bits 25:16 and dots-per-line minus one in bits 9:0, and resets to 0x0270035F (864 dots, 625 lines).
- R2: The dot position advances by one only on cycles with `dot_en` high. After dots-per-line enabled cycles it returns to 0 and the line position advances by one.
- R3: When the line position is at or above the last line and the line ends, it returns to 0. The field flag (status bit 10) toggles at that moment only if interlace (sync-config register, select 1, bit 4) is set.
- R4: When the line position steps from 41 into line 42, `frame_pulse` is high for that one cycle and `frame_count` increments by one.
- R5: Status bits 9:0 show the line position, bit 10 shows the field flag (1 = odd), and bits 15:14 read zero.
- R6: On a line whose bit 0 equals the field flag, bit 12 (hsync off) is set when the dot position exceeds the hsync width. When the line is at or above the vsync line count, bit 13 (vsync off) is also set, and bit 11 (active) is set when the dot position exceeds the front-porch point. Below the vsync line count, bits 13 and 11 are clear.
- R7: On a line of the other parity at or above the vsync line count, bits 13 and 12 are set, and bit 11 is set while dot position plus the back porch (54) is below dots-per-line. Below the vsync line count, only bit 12 is set.
- R8: The sync-time register (select 2) gives the vsync line count in bits 11:8 and the hsync code in bits 6:0. The hsync width is (code + 1) * 2 dots. It resets to 0x07D6A53F.
- R9: The front-porch register (select 3) holds a 10-bit value v. The front-porch point is v + 1 dots. The register resets to 0.
- R10: Reset clears the dot, line and frame counters and `frame_pulse`, sets the field flag to even, and restores the register reset values.
- R11: Register bits outside the defined fields are ignored on write. A timing word with ones in bits 31:26 and 15:10 gives the same line and dot totals as the same word with those bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | Dot-clock enable, one dot per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 timing, 1 sync config, 2 sync time, 3 front porch |
| wr_data | input | 32 | Register write data |
| status_word | output | 16 | Line, field and sync/active status |
| frame_pulse | output | 1 | One-cycle pulse on entering line 42 |
| frame_count | output | 16 | Frames counted |
| dot_pos | output | 10 | Current dot position in the line |
| line_pos | output | 10 | Current line position in the frame |

## Verification
The bench first runs the reset totals with `dot_en` held high, then a short-dot version of the reset line total, so that the line-field layout and the 625-line wrap are both reached. Next it runs a small frame written with junk in the unused bits. That run uses a random `dot_en` and random sync-time and front-porch rewrites, and it separates the matching-parity and other-parity flag rules across many hsync widths, vsync counts and porch points. With interlace on, the field flag must alternate. A total that shrinks below the current line must force an early wrap. A mid-run reset must bring back every default.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int unsigned POS_W = 10;
  localparam int unsigned VS_W  = 4;
  localparam int unsigned HS_W  = 7;

  typedef enum logic [1:0] {
    SEL_TIMING   = 2'd0,
    SEL_SYNCCFG  = 2'd1,
    SEL_SYNCTIME = 2'd2,
    SEL_FPORCH   = 2'd3
  } reg_sel_e;

  localparam logic [31:0] TIMING_MASK   = 32'h03FF_03FF;
  localparam logic [31:0] SYNCCFG_MASK  = 32'h0000_03FF;
  localparam logic [31:0] SYNCTIME_MASK = 32'hFFFF_FF7F;
  localparam logic [31:0] FPORCH_MASK   = 32'h0000_03FF;

  localparam logic [31:0] TIMING_RST   = 32'h0270_035F;
  localparam logic [31:0] SYNCCFG_RST  = 32'h0000_0000;
  localparam logic [31:0] SYNCTIME_RST = 32'h07D6_A53F;
  localparam logic [31:0] FPORCH_RST   = 32'h0000_0000;

  localparam int unsigned ST_FIELD  = 10;
  localparam int unsigned ST_ACTIVE = 11;
  localparam int unsigned ST_HSOFF  = 12;
  localparam int unsigned ST_VSOFF  = 13;

  typedef struct packed {
    logic [POS_W-1:0] lines_m1;
    logic [POS_W-1:0] dots_m1;
    logic             interlace;
    logic [VS_W-1:0]  vs_lines;
    logic [HS_W-1:0]  hs_code;
    logic [POS_W-1:0] fp_code;
  } raster_cfg_t;

endpackage

// File: rtl/raster_cfg_regs.sv
module raster_cfg_regs
  import raster_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output raster_cfg_t cfg
);

  logic [31:0] timing_q,   timing_d;
  logic [31:0] synccfg_q,  synccfg_d;
  logic [31:0] synctime_q, synctime_d;
  logic [31:0] fporch_q,   fporch_d;

  always_comb begin
    timing_d   = timing_q;
    synccfg_d  = synccfg_q;
    synctime_d = synctime_q;
    fporch_d   = fporch_q;
    if (wr_en) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_TIMING:   timing_d   = wr_data & TIMING_MASK;
        SEL_SYNCCFG:  synccfg_d  = wr_data & SYNCCFG_MASK;
        SEL_SYNCTIME: synctime_d = wr_data & SYNCTIME_MASK;
        SEL_FPORCH:   fporch_d   = wr_data & FPORCH_MASK;
        default:      timing_d   = timing_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q   <= TIMING_RST;
      synccfg_q  <= SYNCCFG_RST;
      synctime_q <= SYNCTIME_RST;
      fporch_q   <= FPORCH_RST;
    end else begin
      timing_q   <= timing_d;
      synccfg_q  <= synccfg_d;
      synctime_q <= synctime_d;
      fporch_q   <= fporch_d;
    end
  end

  always_comb begin
    cfg.lines_m1  = timing_q[16 +: POS_W];
    cfg.dots_m1   = timing_q[0 +: POS_W];
    cfg.interlace = synccfg_q[4];
    cfg.vs_lines  = synctime_q[8 +: VS_W];
    cfg.hs_code   = synctime_q[0 +: HS_W];
    cfg.fp_code   = fporch_q[0 +: POS_W];
  end

endmodule

// File: rtl/raster_counter.sv
module raster_counter
  import raster_pkg::*;
#(
  parameter int unsigned FRAME_W    = 16,
  parameter int unsigned FRAME_LINE = 42
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dot_en,
  input  logic [POS_W-1:0]   lines_m1,
  input  logic [POS_W-1:0]   dots_m1,
  input  logic               interlace,
  output logic [POS_W-1:0]   dot_q,
  output logic [POS_W-1:0]   line_q,
  output logic               field_q,
  output logic [FRAME_W-1:0] frames_q,
  output logic               pulse_q
);

  localparam logic [POS_W-1:0] MARK_LINE = POS_W'(FRAME_LINE);

  logic [POS_W-1:0]   dot_d, line_d;
  logic               field_d, pulse_d;
  logic [FRAME_W-1:0] frames_d;
  logic               line_end, frame_end;

  assign line_end  = (dot_q >= dots_m1);
  assign frame_end = (line_q >= lines_m1);

  always_comb begin
    dot_d    = dot_q;
    line_d   = line_q;
    field_d  = field_q;
    frames_d = frames_q;
    pulse_d  = 1'b0;
    if (dot_en) begin
      if (line_end) begin
        dot_d = '0;
        if (frame_end) begin
          line_d = '0;
          if (interlace) field_d = ~field_q;
        end else begin
          line_d = line_q + 1'b1;
          if (line_d == MARK_LINE) begin
            pulse_d  = 1'b1;
            frames_d = frames_q + 1'b1;
          end
        end
      end else begin
        dot_d = dot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q    <= '0;
      line_q   <= '0;
      field_q  <= 1'b0;
      frames_q <= '0;
      pulse_q  <= 1'b0;
    end else begin
      dot_q    <= dot_d;
      line_q   <= line_d;
      field_q  <= field_d;
      frames_q <= frames_d;
      pulse_q  <= pulse_d;
    end
  end

endmodule

// File: rtl/raster_status.sv
module raster_status
  import raster_pkg::*;
#(
  parameter int unsigned BACK_PORCH = 54
) (
  input  logic [POS_W-1:0] line,
  input  logic [POS_W-1:0] dot,
  input  logic             field,
  input  logic [VS_W-1:0]  vs_lines,
  input  logic [HS_W-1:0]  hs_code,
  input  logic [POS_W-1:0] fp_code,
  input  logic [POS_W-1:0] dots_m1,
  output logic [15:0]      status
);

  localparam int unsigned CW = POS_W + 2;

  logic [CW-1:0] dot_w, hs_w, fp_w, end_w, bp_w;
  logic          same_par, below_vs;

  always_comb begin
    dot_w    = CW'(dot);
    hs_w     = (CW'(hs_code) + CW'(1)) << 1;
    fp_w     = CW'(fp_code) + CW'(1);
    end_w    = CW'(dots_m1) + CW'(1);
    bp_w     = CW'(BACK_PORCH);
    same_par = (line[0] == field);
    below_vs = (line < POS_W'(vs_lines));
  end

  always_comb begin
    status = '0;
    status[POS_W-1:0] = line;
    status[ST_FIELD]  = field;
    if (same_par) begin
      status[ST_HSOFF] = (dot_w > hs_w);
      if (!below_vs) begin
        status[ST_VSOFF]  = 1'b1;
        status[ST_ACTIVE] = (dot_w > fp_w);
      end
    end else begin
      status[ST_HSOFF] = 1'b1;
      if (!below_vs) begin
        status[ST_VSOFF]  = 1'b1;
        status[ST_ACTIVE] = ((dot_w + bp_w) < end_w);
      end
    end
  end

endmodule

// File: rtl/raster_timing.sv
module raster_timing
  import raster_pkg::*;
#(
  parameter int unsigned FRAME_W    = 16,
  parameter int unsigned FRAME_LINE = 42,
  parameter int unsigned BACK_PORCH = 54
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dot_en,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [31:0]        wr_data,
  output logic [15:0]        status_word,
  output logic               frame_pulse,
  output logic [FRAME_W-1:0] frame_count,
  output logic [POS_W-1:0]   dot_pos,
  output logic [POS_W-1:0]   line_pos
);

  raster_cfg_t      cfg;
  logic             field_w;
  logic [VS_W-1:0]  vs_lines_w;
  logic             interlace_w;

  assign vs_lines_w  = cfg.vs_lines;
  assign interlace_w = cfg.interlace;

  raster_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cfg     (cfg)
  );

  raster_counter #(
    .FRAME_W    (FRAME_W),
    .FRAME_LINE (FRAME_LINE)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .dot_en    (dot_en),
    .lines_m1  (cfg.lines_m1),
    .dots_m1   (cfg.dots_m1),
    .interlace (cfg.interlace),
    .dot_q     (dot_pos),
    .line_q    (line_pos),
    .field_q   (field_w),
    .frames_q  (frame_count),
    .pulse_q   (frame_pulse)
  );

  raster_status #(
    .BACK_PORCH (BACK_PORCH)
  ) u_stat (
    .line     (line_pos),
    .dot      (dot_pos),
    .field    (field_w),
    .vs_lines (cfg.vs_lines),
    .hs_code  (cfg.hs_code),
    .fp_code  (cfg.fp_code),
    .dots_m1  (cfg.dots_m1),
    .status   (status_word)
  );

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
  import raster_pkg::*;
#(
  parameter int unsigned FRAME_W    = 16,
  parameter int unsigned FRAME_LINE = 42
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dot_en,
  input logic [15:0]        status_word,
  input logic               frame_pulse,
  input logic [FRAME_W-1:0] frame_count,
  input logic [POS_W-1:0]   dot_pos,
  input logic [POS_W-1:0]   line_pos,
  input logic [VS_W-1:0]    vs_lines,
  input logic               interlace
);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> ($stable(dot_pos) && $stable(line_pos) && !frame_pulse));

  a_r4_pulse_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (line_pos == POS_W'(FRAME_LINE) && dot_pos == '0));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (frame_count == $past(frame_count) + 1'b1));

  a_r3_field_flip_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_word[ST_FIELD]) |-> (line_pos == '0 && dot_pos == '0 && $past(interlace)));

  a_r6_quiet_below_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pos[0] == status_word[ST_FIELD] && line_pos < POS_W'(vs_lines))
      |-> (!status_word[ST_VSOFF] && !status_word[ST_ACTIVE]));

  a_r7_other_parity_syncs: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pos[0] != status_word[ST_FIELD] && line_pos >= POS_W'(vs_lines))
      |-> (status_word[ST_VSOFF] && status_word[ST_HSOFF]));

  a_r5_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[15:14] == 2'b00);

endmodule

bind raster_timing raster_timing_chk #(
  .FRAME_W    (FRAME_W),
  .FRAME_LINE (FRAME_LINE)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .dot_en      (dot_en),
  .status_word (status_word),
  .frame_pulse (frame_pulse),
  .frame_count (frame_count),
  .dot_pos     (dot_pos),
  .line_pos    (line_pos),
  .vs_lines    (vs_lines_w),
  .interlace   (interlace_w)
);

// File: tb/raster_timing_tb_top.sv
module raster_timing_tb_top;

  localparam int BP = 54;
  localparam int MARK = 42;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dot_en;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [15:0] status_word;
  logic        frame_pulse;
  logic [15:0] frame_count;
  logic [9:0]  dot_pos;
  logic [9:0]  line_pos;

  always #10 clk = ~clk;

  raster_timing dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dot_en      (dot_en),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .status_word (status_word),
    .frame_pulse (frame_pulse),
    .frame_count (frame_count),
    .dot_pos     (dot_pos),
    .line_pos    (line_pos)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R10";

  // reference state
  int m_dot, m_line, m_field, m_frames, m_pulse;
  int m_lines_m1, m_dots_m1, m_ilace, m_vs, m_hsw, m_fp;

  function automatic void model_reset();
    m_dot = 0; m_line = 0; m_field = 0; m_frames = 0; m_pulse = 0;
    m_lines_m1 = 'h270; m_dots_m1 = 'h35F; m_ilace = 0;
    m_vs = 5; m_hsw = 'h3F; m_fp = 0;
  endfunction

  function automatic int exp_status();
    int st, hsd;
    st  = m_line | (m_field << 10);
    hsd = (m_hsw + 1) * 2;
    if ((m_line & 1) == m_field) begin
      if (m_dot > hsd) st |= 'h1000;
      if (m_line >= m_vs) begin
        st |= 'h2000;
        if (m_dot > m_fp + 1) st |= 'h0800;
      end
    end else begin
      st |= 'h1000;
      if (m_line >= m_vs) begin
        st |= 'h2000;
        if (m_dot + BP < m_dots_m1 + 1) st |= 'h0800;
      end
    end
    return st;
  endfunction

  function automatic void model_advance(bit en, bit we, int sel, logic [31:0] d);
    m_pulse = 0;
    if (en) begin
      if (m_dot >= m_dots_m1) begin
        m_dot = 0;
        if (m_line >= m_lines_m1) begin
          m_line = 0;
          if (m_ilace != 0) m_field ^= 1;
        end else begin
          m_line++;
          if (m_line == MARK) begin
            m_pulse = 1;
            m_frames = (m_frames + 1) & 'hFFFF;
          end
        end
      end else m_dot++;
    end
    if (we) begin
      case (sel)
        0: begin m_lines_m1 = int'(d[25:16]); m_dots_m1 = int'(d[9:0]); end
        1: m_ilace = int'(d[4]);
        2: begin m_vs = int'(d[11:8]); m_hsw = int'(d[6:0]); end
        default: m_fp = int'(d[9:0]);
      endcase
    end
  endfunction

  task automatic compare_all();
    string tag;
    checks++;
    if (int'(dot_pos) != m_dot || int'(line_pos) != m_line) begin
      errors++;
      $display("FAIL R2/R3 [%s] pos dot=%0d line=%0d expected dot=%0d line=%0d",
               phase, dot_pos, line_pos, m_dot, m_line);
    end
    checks++;
    if (int'(frame_pulse) != m_pulse || int'(frame_count) != m_frames) begin
      errors++;
      $display("FAIL R4 [%s] pulse=%0d count=%0d expected pulse=%0d count=%0d",
               phase, frame_pulse, frame_count, m_pulse, m_frames);
    end
    checks++;
    tag = ((m_line & 1) == m_field) ? "R5/R6" : "R5/R7";
    if (int'(status_word) != exp_status()) begin
      errors++;
      $display("FAIL %s [%s] status=%h expected %h (line %0d dot %0d)",
               tag, phase, status_word, exp_status()[15:0], m_line, m_dot);
    end
  endtask

  task automatic step(bit en, bit we, int sel, logic [31:0] d);
    dot_en  = en;
    wr_en   = we;
    wr_sel  = sel[1:0];
    wr_data = d;
    model_advance(en, we, sel, d);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n, int en_pct, int wr_pct, bit fp_only);
    for (int i = 0; i < n; i++) begin
      bit en, we;
      int sel;
      logic [31:0] d;
      en  = ($urandom % 100) < en_pct;
      we  = (wr_pct > 0) && (($urandom % 100) < wr_pct);
      sel = 3;
      d   = $urandom;
      if (we) begin
        if (!fp_only && ($urandom % 2) == 0) begin
          sel = 2;
          d[6:0]  = 7'($urandom % 40);
          d[11:8] = 4'($urandom % 9);
        end else begin
          d[9:0] = 10'($urandom % 80);
        end
      end
      step(en, we, sel, d);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    dot_en = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R10";
    compare_all();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    dot_en = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    do_reset();

    // R1: reset totals, 864 dots per line
    phase = "R1";
    run(1800, 100, 0, 0);
    // R1: line field layout, 625 lines with short lines
    step(1, 1, 0, 32'h0270_0013);
    run(12600, 100, 0, 0);

    // R11: junk in unused bits, small frame 50 x 80
    phase = "R11";
    step(1, 1, 0, 32'hFC31_FC4F);
    step(1, 1, 2, 32'hABCD_F483);
    step(1, 1, 3, 32'hFFFF_FC05);
    run(4100, 75, 0, 0);

    // R8: sync-time and porch rewrites mid-run
    phase = "R8";
    run(8000, 80, 3, 0);
    // R9: front-porch point sweeps
    phase = "R9";
    run(4000, 90, 4, 1);

    // R3: interlace on, field alternates each wrap
    phase = "R3";
    step(1, 1, 1, 32'hFFFF_FC10);
    run(12000, 85, 1, 0);
    // R3: shrink total below current line, forcing an early wrap
    while (m_line < 30) step(1, 0, 0, 32'h0);
    step(1, 1, 0, 32'h0013_004F);
    run(3000, 90, 0, 0);
    step(1, 1, 1, 32'h0000_0000);
    run(3000, 90, 0, 0);

    // R10: reset mid-run restores defaults and even field
    do_reset();
    phase = "R1";
    run(900, 100, 0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule